// File: doc/BRIEF.md
# Card read DMA sequencer

This block steers the receive side of a memory-card host controller while a DMA engine moves read data out of the receive FIFO. Software programs a small control register (DMA enable, block chaining, transfer-select field) and a block count, then starts a command. The sequencer waits for the card's command response, then waits for each data block. The serializer, CRC logic and clock generation sit outside and report through single-cycle strobes. While the sequence runs and DMA is enabled, a non-empty FIFO raises a DMA request. Each acknowledge removes one word.

With chaining on, every block that finishes cleanly re-arms the wait for the next one until the block count runs out. Then a block-end flag rises and busy drops. Data left in the FIFO after the sequence can be moved out by selecting the drain code in the control register. Errors are handled by phase. A failure during the response phase stops the command and wipes the control register but keeps the FIFO. A failure during the data phase does the same and also flushes the FIFO.

Top module: `card_rd_dma_seq`

## Requirements
- R1: During reset and right after it, dma_req, busy and cmd_off are 0. ctl_q, flags, blk_left and fifo_lvl are also 0.
- R2: dma_req is 1 only when ctl_q bit0 (DMA enable) is 1, the FIFO holds at least one word, and either busy is 1 or the drain code is selected. With enable at 0, no request is made even while a command runs.
- R3: Words leave the FIFO in arrival order, and dma_rdata shows the oldest word. dma_ack pops a word only in a cycle where dma_req is 1; at other times it is ignored. A push into a full FIFO is dropped unless a pop happens in the same cycle.
- R4: Writing 3'b100 to ctl_q bits[4:2] (the drain code), with enable set, raises requests outside a sequence until the FIFO is empty.
- R5: After a command start, the response must arrive within CMD_TO cycles. Cycle 0 is the first cycle of the wait, and a response in cycle CMD_TO-1 is still accepted. Otherwise flags bit1 (command timeout) is set.
- R6: A response CRC error or a command timeout sets cmd_off and clears the control register to 0. The FIFO is left unchanged. A response CRC error sets flags bit2.
- R7: A data CRC error, or no block end within DAT_TO cycles of a block wait, sets cmd_off, clears the control register and flushes the FIFO. A data CRC error sets flags bit2; a data timeout sets flags bit3.
- R8: blk_left loads the block count on a command start, and a count of 0 is taken as 1. Each clean block end decrements it. With ctl_q bit1 (chain) set, the next block wait starts at once. With chain clear, the sequence returns to idle after that block.
- R9: The block that brings blk_left to 0 sets flags bit0 (block-transfer end) and drops busy at the same edge.
- R10: All flags are sticky and are cleared by writing 1 to the bit through flag_clr. A new set event in the same cycle wins over the clear. cmd_off stays set until the next accepted command start.
- R11: cmd_start is ignored while busy. fifo_clr empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control value: bit0 enable, bit1 chain, bits[4:2] select |
| bcnt_wr | input | 1 | Block count register write strobe |
| bcnt_wdata | input | BCW | Block count value |
| cmd_start | input | 1 | Start a read command |
| fifo_clr | input | 1 | Empty the receive FIFO |
| resp_ok | input | 1 | Command response received intact |
| resp_crc_err | input | 1 | Command response CRC failure |
| blk_ok | input | 1 | Data block received intact |
| dat_crc_err | input | 1 | Data block CRC failure |
| rx_push | input | 1 | Word from the card into the FIFO |
| rx_data | input | DW | Received word |
| dma_ack | input | 1 | DMA acknowledge, takes one word |
| dma_req | output | 1 | DMA request |
| dma_rdata | output | DW | Oldest FIFO word |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr | input | 4 | Write-one-to-clear mask |
| flags | output | 4 | bit0 block end, bit1 command timeout, bit2 CRC, bit3 data timeout |
| cmd_off | output | 1 | Command stopped by an error |
| busy | output | 1 | Sequence in progress |
| ctl_q | output | 5 | Control register contents |
| blk_left | output | BCW | Blocks still to receive |
| fifo_lvl | output | LW | Words held in the FIFO |

## Verification
The bench builds the block with DEPTH=4, CMD_TO=6, DAT_TO=10 and BCW=4. The shallow FIFO fills within a few pushes, so dropped pushes on a full FIFO and push-with-pop at full can be reached. The short windows put both timeouts, and a response in the last allowed cycle, only a handful of cycles after a command start. A four-bit count keeps multi-block chains and the zero-count case short.

// File: rtl/card_rd_pkg.sv
package card_rd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RESP = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [2:0] sel;
    logic       chain;
    logic       en;
  } ctl_t;

  localparam logic [2:0] SEL_DRAIN = 3'b100;

  localparam int FLG_BTI = 0;
  localparam int FLG_CTO = 1;
  localparam int FLG_CRC = 2;
  localparam int FLG_DTO = 3;
  localparam int NFLG    = 4;

  function automatic logic drain_selected(input ctl_t c);
    return c.sel == SEL_DRAIN;
  endfunction

endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 2) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire full    = (level == LW'(DEPTH));
  wire pop_ok  = pop && (level != '0);
  wire push_ok = push && (!full || pop_ok);

  always_ff @(posedge clk) begin
    if (!flush && push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  assign head = mem[rp];

endmodule

// File: rtl/rd_seq_ctrl.sv
module rd_seq_ctrl
  import card_rd_pkg::*;
#(
  parameter int CMD_TO = 64,
  parameter int DAT_TO = 256,
  parameter int BCW    = 8,
  localparam int TMAX  = (CMD_TO > DAT_TO) ? CMD_TO : DAT_TO,
  localparam int TW    = $clog2(TMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_start,
  input  logic           chain,
  input  logic           resp_ok,
  input  logic           resp_crc,
  input  logic           blk_ok,
  input  logic           dat_crc,
  input  logic [BCW-1:0] bcnt_reg,
  output seq_state_e     state,
  output logic [BCW-1:0] blk_left,
  output logic           ev_start,
  output logic           ev_cmd_crc,
  output logic           ev_cmd_to,
  output logic           ev_dat_crc,
  output logic           ev_dat_to,
  output logic           ev_blk_done,
  output logic           ev_last_blk
);

  logic [TW-1:0] tmr;

  function automatic logic [BCW-1:0] blk_load(input logic [BCW-1:0] n);
    return (n == '0) ? BCW'(1) : n;
  endfunction

  wire in_idle = (state == SEQ_IDLE);
  wire in_resp = (state == SEQ_RESP);
  wire in_data = (state == SEQ_DATA);
  wire cmd_win_end = (tmr == TW'(CMD_TO - 1));
  wire dat_win_end = (tmr == TW'(DAT_TO - 1));

  assign ev_start    = in_idle && cmd_start;
  assign ev_cmd_crc  = in_resp && resp_crc;
  assign ev_cmd_to   = in_resp && !resp_crc && !resp_ok && cmd_win_end;
  assign ev_dat_crc  = in_data && dat_crc;
  assign ev_blk_done = in_data && !dat_crc && blk_ok;
  assign ev_last_blk = ev_blk_done && (blk_left == BCW'(1));
  assign ev_dat_to   = in_data && !dat_crc && !blk_ok && dat_win_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      tmr      <= '0;
      blk_left <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (cmd_start) begin
            state    <= SEQ_RESP;
            tmr      <= '0;
            blk_left <= blk_load(bcnt_reg);
          end
        end
        SEQ_RESP: begin
          if (ev_cmd_crc || ev_cmd_to) begin
            state <= SEQ_IDLE;
          end else if (resp_ok) begin
            state <= SEQ_DATA;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SEQ_DATA: begin
          if (ev_dat_crc || ev_dat_to) begin
            state <= SEQ_IDLE;
          end else if (ev_blk_done) begin
            blk_left <= blk_left - 1'b1;
            tmr      <= '0;
            if (ev_last_blk || !chain) state <= SEQ_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  function automatic logic [N-1:0] next_flags(input logic [N-1:0] cur,
                                              input logic [N-1:0] s,
                                              input logic         w,
                                              input logic [N-1:0] c);
    return (cur & ~(w ? c : '0)) | s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_flags(q, set, clr_wr, clr);
  end

endmodule

// File: rtl/card_rd_dma_seq.sv
module card_rd_dma_seq
  import card_rd_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int BCW    = 8,
  parameter int CMD_TO = 64,
  parameter int DAT_TO = 256,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic [4:0]      ctl_wdata,
  input  logic            bcnt_wr,
  input  logic [BCW-1:0]  bcnt_wdata,
  input  logic            cmd_start,
  input  logic            fifo_clr,
  input  logic            resp_ok,
  input  logic            resp_crc_err,
  input  logic            blk_ok,
  input  logic            dat_crc_err,
  input  logic            rx_push,
  input  logic [DW-1:0]   rx_data,
  input  logic            dma_ack,
  output logic            dma_req,
  output logic [DW-1:0]   dma_rdata,
  input  logic            flag_clr_wr,
  input  logic [NFLG-1:0] flag_clr,
  output logic [NFLG-1:0] flags,
  output logic            cmd_off,
  output logic            busy,
  output logic [4:0]      ctl_q,
  output logic [BCW-1:0]  blk_left,
  output logic [LW-1:0]   fifo_lvl
);

  ctl_t           ctl;
  logic [BCW-1:0] bcnt_reg;
  seq_state_e     seq_state;
  logic           ev_start, ev_cmd_crc, ev_cmd_to, ev_dat_crc, ev_dat_to;
  logic           ev_blk_done, ev_last_blk;

  wire seq_in_resp = (seq_state == SEQ_RESP);
  wire err_cmd     = ev_cmd_crc || ev_cmd_to;
  wire err_dat     = ev_dat_crc || ev_dat_to;
  wire fifo_flush  = fifo_clr || err_dat;
  wire dma_pop     = dma_req && dma_ack;

  rd_seq_ctrl #(
    .CMD_TO (CMD_TO),
    .DAT_TO (DAT_TO),
    .BCW    (BCW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .chain       (ctl.chain),
    .resp_ok     (resp_ok),
    .resp_crc    (resp_crc_err),
    .blk_ok      (blk_ok),
    .dat_crc     (dat_crc_err),
    .bcnt_reg    (bcnt_reg),
    .state       (seq_state),
    .blk_left    (blk_left),
    .ev_start    (ev_start),
    .ev_cmd_crc  (ev_cmd_crc),
    .ev_cmd_to   (ev_cmd_to),
    .ev_dat_crc  (ev_dat_crc),
    .ev_dat_to   (ev_dat_to),
    .ev_blk_done (ev_blk_done),
    .ev_last_blk (ev_last_blk)
  );

  rx_fifo #(
    .DW    (DW),
    .DEPTH (DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (fifo_flush),
    .push  (rx_push),
    .din   (rx_data),
    .pop   (dma_pop),
    .head  (dma_rdata),
    .level (fifo_lvl)
  );

  logic [NFLG-1:0] flg_set;
  always_comb begin
    flg_set          = '0;
    flg_set[FLG_BTI] = ev_last_blk;
    flg_set[FLG_CTO] = ev_cmd_to;
    flg_set[FLG_CRC] = ev_cmd_crc || ev_dat_crc;
    flg_set[FLG_DTO] = ev_dat_to;
  end

  sticky_flags #(.N(NFLG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (flg_set),
    .clr_wr (flag_clr_wr),
    .clr    (flag_clr),
    .q      (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      bcnt_reg <= '0;
      cmd_off  <= 1'b0;
    end else begin
      if (err_cmd || err_dat) ctl <= '0;
      else if (ctl_wr)        ctl <= ctl_t'(ctl_wdata);
      if (bcnt_wr) bcnt_reg <= bcnt_wdata;
      if (err_cmd || err_dat) cmd_off <= 1'b1;
      else if (ev_start)      cmd_off <= 1'b0;
    end
  end

  assign busy    = (seq_state != SEQ_IDLE);
  assign ctl_q   = ctl;
  assign dma_req = ctl.en && (fifo_lvl != '0) && (busy || drain_selected(ctl));

endmodule

// File: rtl/card_rd_dma_chk.sv
module card_rd_dma_chk #(
  parameter int DEPTH  = 16,
  parameter int LW     = 5,
  parameter int CMD_TO = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_resp,
  input logic          ev_cmd_crc,
  input logic          ev_cmd_to,
  input logic          ev_dat_crc,
  input logic          ev_dat_to,
  input logic          ev_last_blk,
  input logic          dma_req,
  input logic          dma_ack,
  input logic          fifo_clr,
  input logic          rx_push,
  input logic [4:0]    ctl_q,
  input logic [LW-1:0] fifo_lvl,
  input logic          cmd_off,
  input logic          busy,
  input logic [3:0]    flags,
  input logic          flag_clr_wr,
  input logic [3:0]    flag_clr
);

  int unsigned resp_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_cyc <= 0;
    else if (in_resp) resp_cyc <= resp_cyc + 1;
    else              resp_cyc <= 0;
  end

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |-> !dma_req); // R2
  AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (fifo_lvl != '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_lvl <= LW'(DEPTH)); // R3
  AST_CMD_TO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_to |-> (resp_cyc == CMD_TO - 1)); // R5
  AST_CMD_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_to || ev_cmd_crc) |=> (cmd_off && ctl_q == '0)); // R6
  AST_CMD_ERR_KEEPS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_cmd_to || ev_cmd_crc) && !fifo_clr && !rx_push && !(dma_req && dma_ack))
      |=> (fifo_lvl == $past(fifo_lvl))); // R6
  AST_DAT_ERR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dat_crc || ev_dat_to) |=> (fifo_lvl == '0 && ctl_q == '0 && cmd_off)); // R7
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_cmd_crc, ev_cmd_to, ev_dat_crc, ev_dat_to, ev_last_blk})); // R7
  AST_LAST_BLK_END: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_blk |=> (flags[0] && !busy)); // R9
  AST_CTO_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_wr && flag_clr[1] && !ev_cmd_to) |=> !flags[1]); // R10

endmodule

bind card_rd_dma_seq card_rd_dma_chk #(
  .DEPTH  (DEPTH),
  .LW     (LW),
  .CMD_TO (CMD_TO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_resp     (seq_in_resp),
  .ev_cmd_crc  (ev_cmd_crc),
  .ev_cmd_to   (ev_cmd_to),
  .ev_dat_crc  (ev_dat_crc),
  .ev_dat_to   (ev_dat_to),
  .ev_last_blk (ev_last_blk),
  .dma_req     (dma_req),
  .dma_ack     (dma_ack),
  .fifo_clr    (fifo_clr),
  .rx_push     (rx_push),
  .ctl_q       (ctl_q),
  .fifo_lvl    (fifo_lvl),
  .cmd_off     (cmd_off),
  .busy        (busy),
  .flags       (flags),
  .flag_clr_wr (flag_clr_wr),
  .flag_clr    (flag_clr)
);

// File: tb/sim_card_rd_dma_seq.sv
module sim_card_rd_dma_seq;

  localparam int DW = 8, DEPTH = 4, BCW = 4, CMD_TO = 6, DAT_TO = 10;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, bcnt_wr = 0, cmd_start = 0, fifo_clr = 0;
  logic resp_ok = 0, resp_crc_err = 0, blk_ok = 0, dat_crc_err = 0;
  logic rx_push = 0, dma_ack = 0, flag_clr_wr = 0;
  logic [4:0] ctl_wdata = '0;
  logic [BCW-1:0] bcnt_wdata = '0;
  logic [DW-1:0] rx_data = '0;
  logic [3:0] flag_clr = '0;
  logic dma_req, cmd_off, busy;
  logic [DW-1:0] dma_rdata;
  logic [3:0] flags;
  logic [4:0] ctl_q;
  logic [BCW-1:0] blk_left;
  logic [LW-1:0] fifo_lvl;

  card_rd_dma_seq #(.DW(DW), .DEPTH(DEPTH), .BCW(BCW), .CMD_TO(CMD_TO), .DAT_TO(DAT_TO)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .bcnt_wr(bcnt_wr), .bcnt_wdata(bcnt_wdata), .cmd_start(cmd_start),
    .fifo_clr(fifo_clr), .resp_ok(resp_ok), .resp_crc_err(resp_crc_err),
    .blk_ok(blk_ok), .dat_crc_err(dat_crc_err), .rx_push(rx_push),
    .rx_data(rx_data), .dma_ack(dma_ack), .dma_req(dma_req),
    .dma_rdata(dma_rdata), .flag_clr_wr(flag_clr_wr), .flag_clr(flag_clr),
    .flags(flags), .cmd_off(cmd_off), .busy(busy), .ctl_q(ctl_q),
    .blk_left(blk_left), .fifo_lvl(fifo_lvl)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, ack_mode = 0;
  bit done = 0;
  logic [DW-1:0] word_val = 8'h10;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [4:0] m_ctl;
  int m_bcnt, m_st, m_tmr, m_left;
  bit m_off;
  logic [3:0] m_flags;
  logic [DW-1:0] m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = '0; m_bcnt = 0; m_st = 0; m_tmr = 0; m_left = 0; m_off = 0;
      m_flags = '0; m_q.delete();
    end else begin
      bit req, pop, clr_ctl, flush;
      logic [3:0] nf;
      int old_sz;
      nf = '0; clr_ctl = 0; flush = 0;
      req = m_ctl[0] && m_q.size() > 0 && (m_st != 0 || m_ctl[4:2] == 3'b100);
      pop = req && dma_ack;
      if (m_st == 0) begin
        if (cmd_start) begin
          m_st = 1; m_tmr = 0; m_left = (m_bcnt == 0) ? 1 : m_bcnt; m_off = 0;
        end
      end else if (m_st == 1) begin
        if (resp_crc_err) begin nf[2] = 1; clr_ctl = 1; m_off = 1; m_st = 0; end
        else if (resp_ok) begin m_st = 2; m_tmr = 0; end
        else if (m_tmr == CMD_TO - 1) begin nf[1] = 1; clr_ctl = 1; m_off = 1; m_st = 0; end
        else m_tmr++;
      end else begin
        if (dat_crc_err) begin nf[2] = 1; clr_ctl = 1; flush = 1; m_off = 1; m_st = 0; end
        else if (blk_ok) begin
          if (m_left == 1) begin m_left = 0; nf[0] = 1; m_st = 0; end
          else begin m_left--; m_tmr = 0; if (!m_ctl[1]) m_st = 0; end
        end
        else if (m_tmr == DAT_TO - 1) begin nf[3] = 1; clr_ctl = 1; flush = 1; m_off = 1; m_st = 0; end
        else m_tmr++;
      end
      old_sz = m_q.size();
      if (flush || fifo_clr) m_q.delete();
      else begin
        if (pop) void'(m_q.pop_front());
        if (rx_push && (old_sz < DEPTH || pop)) m_q.push_back(rx_data);
      end
      if (clr_ctl) m_ctl = '0;
      else if (ctl_wr) m_ctl = ctl_wdata;
      if (bcnt_wr) m_bcnt = int'(bcnt_wdata);
      m_flags = (m_flags & ~(flag_clr_wr ? flag_clr : 4'b0)) | nf;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit ereq;
      ereq = m_ctl[0] && m_q.size() > 0 && (m_st != 0 || m_ctl[4:2] == 3'b100);
      check("R2 dma_req", 32'(dma_req), 32'(ereq));
      if (ereq) check("R3 dma_rdata", 32'(dma_rdata), 32'(m_q[0]));
      check("R7 fifo_lvl", 32'(fifo_lvl), 32'(m_q.size()));
      check("R6 ctl_q", 32'(ctl_q), 32'(m_ctl));
      check("R6 cmd_off", 32'(cmd_off), 32'(m_off));
      check("R9 busy", 32'(busy), 32'(m_st != 0));
      check("R8 blk_left", 32'(blk_left), 32'(m_left));
      check("R9 bti", 32'(flags[0]), 32'(m_flags[0]));
      check("R5 cto", 32'(flags[1]), 32'(m_flags[1]));
      check("R6 crc", 32'(flags[2]), 32'(m_flags[2]));
      check("R7 dto", 32'(flags[3]), 32'(m_flags[3]));
    end
    case (ack_mode)
      1:       dma_ack <= (cyc % 3) != 2;
      2:       dma_ack <= 1'b1;
      default: dma_ack <= 1'b0;
    endcase
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; bcnt_wr = 0; cmd_start = 0; fifo_clr = 0; resp_ok = 0;
    resp_crc_err = 0; blk_ok = 0; dat_crc_err = 0; rx_push = 0;
    flag_clr_wr = 0; flag_clr = '0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_wr = 1; ctl_wdata = v; step();
  endtask

  task automatic wr_bcnt(input int v);
    bcnt_wr = 1; bcnt_wdata = BCW'(v); step();
  endtask

  task automatic push_word();
    rx_push = 1; rx_data = word_val; word_val = word_val + 8'h07; step();
  endtask

  task automatic clr_all_flags();
    flag_clr_wr = 1; flag_clr = 4'hF; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 dma_req", 32'(dma_req), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 cmd_off", 32'(cmd_off), 0);
    check("R1 flags", 32'(flags), 0);
    check("R1 ctl_q", 32'(ctl_q), 0);
    check("R1 fifo_lvl", 32'(fifo_lvl), 0);
    check("R1 blk_left", 32'(blk_left), 0);
    rst_n = 1;
    step();

    // R8: three-block chained read with DMA draining on the fly
    ack_mode = 1;
    wr_bcnt(3);
    wr_ctl(5'b00011);
    cmd_start = 1; step();
    steps(2);
    resp_ok = 1; step();
    push_word(); push_word(); push_word();
    blk_ok = 1; step();
    check("R8 chained busy", 32'(busy), 1);
    push_word(); steps(2); push_word();
    blk_ok = 1; step();
    push_word();
    blk_ok = 1; rx_push = 1; rx_data = 8'hA5; step();
    check("R9 busy after last", 32'(busy), 0);
    check("R9 bti set", 32'(flags[0]), 1);
    steps(8);
    clr_all_flags();

    // R5/R6: command timeout keeps FIFO contents
    ack_mode = 0;
    fifo_clr = 1; step();
    wr_ctl(5'b00001);
    push_word(); push_word();
    cmd_start = 1; step();
    steps(CMD_TO + 2);
    check("R5 cto flag", 32'(flags[1]), 1);
    check("R6 ctl cleared", 32'(ctl_q), 0);
    check("R6 fifo kept", 32'(fifo_lvl), 2);
    // R10: write one to clear
    flag_clr_wr = 1; flag_clr = 4'b0010; step();
    check("R10 cto cleared", 32'(flags[1]), 0);

    // R5: response in the last allowed cycle, then R7 data timeout flushes
    wr_ctl(5'b00011);
    wr_bcnt(2);
    cmd_start = 1; step();
    check("R10 cmd_off cleared on start", 32'(cmd_off), 0);
    steps(CMD_TO - 1);
    resp_ok = 1; step();
    check("R5 last-cycle response accepted", 32'(busy), 1);
    check("R5 no timeout", 32'(flags[1]), 0);
    push_word();
    steps(DAT_TO + 2);
    check("R7 dto flag", 32'(flags[3]), 1);
    check("R7 fifo flushed", 32'(fifo_lvl), 0);
    clr_all_flags();

    // R6: response CRC error
    push_word();
    wr_ctl(5'b00001);
    cmd_start = 1; step();
    resp_crc_err = 1; step();
    check("R6 crc flag", 32'(flags[2]), 1);
    check("R6 cmd_off", 32'(cmd_off), 1);
    check("R6 fifo kept after crc", 32'(fifo_lvl), 1);
    clr_all_flags();

    // R8/R7: zero count acts as one, then data CRC error
    fifo_clr = 1; step();
    wr_ctl(5'b00011);
    wr_bcnt(0);
    cmd_start = 1; step();
    check("R8 zero count loads one", 32'(blk_left), 1);
    resp_ok = 1; step();
    push_word();
    dat_crc_err = 1; blk_ok = 1; step();
    check("R7 crc flush", 32'(fifo_lvl), 0);
    check("R7 crc flag", 32'(flags[2]), 1);
    clr_all_flags();

    // R8/R2/R4: unchained block leaves data, drain code empties it
    wr_ctl(5'b00001);
    wr_bcnt(2);
    cmd_start = 1; step();
    resp_ok = 1; step();
    push_word(); push_word(); push_word();
    blk_ok = 1; step();
    check("R8 unchained returns idle", 32'(busy), 0);
    check("R8 one block left", 32'(blk_left), 1);
    steps(2);
    check("R2 no req after sequence", 32'(dma_req), 0);
    wr_ctl(5'b10001);
    check("R4 drain raises req", 32'(dma_req), 1);
    ack_mode = 1;
    steps(12);
    check("R4 drained", 32'(fifo_lvl), 0);
    check("R4 req dropped", 32'(dma_req), 0);
    ack_mode = 0;

    // R2/R3: enable off while busy, acks ignored
    wr_ctl(5'b00000);
    cmd_start = 1; step();
    resp_ok = 1; step();
    ack_mode = 2;
    push_word(); push_word();
    steps(3);
    check("R2 no req without enable", 32'(dma_req), 0);
    check("R3 ack ignored", 32'(fifo_lvl), 2);
    ack_mode = 0;
    blk_ok = 1; step();

    // R3: overflow drop, then push with pop while full
    push_word(); push_word(); push_word(); push_word();
    check("R3 full level", 32'(fifo_lvl), DEPTH);
    wr_ctl(5'b10001);
    ack_mode = 2;
    step();
    push_word(); push_word();
    ack_mode = 0;
    steps(2);

    // R11: start while busy ignored, fifo_clr empties
    fifo_clr = 1; step();
    check("R11 fifo_clr", 32'(fifo_lvl), 0);
    wr_ctl(5'b00011);
    wr_bcnt(5);
    cmd_start = 1; step();
    resp_ok = 1; step();
    wr_bcnt(2);
    cmd_start = 1; step();
    check("R11 start ignored while busy", 32'(blk_left), 5);
    check("R11 still busy", 32'(busy), 1);
    steps(DAT_TO + 2);
    steps(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule